// File: doc/BRIEF.md
# Two-Way Set-Associative Cache Controller

This block sits between a processor word port and a slower main memory that moves whole lines. A word address is cut into three fields: a tag, a set index and a word offset within the line. Both ways of the selected set are compared against the tag in the same cycle, and a way only counts as a hit when its stored tag matches and its valid bit is set. A read hit returns the word and a write hit updates it. On a miss the controller fetches the whole line from memory into a chosen way and then completes the request as a hit.

Two build-time parameters shape the behaviour. `WRITE_BACK` selects between write-back, where a dirty bit per line defers memory writes until that line is evicted, and write-through, where every processor write also goes to memory before the processor is released. `REPL_LRU` selects between least-recently-used and first-in-first-out victim choice. An empty way in the set is always filled before any valid way is displaced. The processor holds its request stable until `cpu_done` pulses. The memory side holds its request until `mem_ack`.

Top module: `sa_cache`

## Requirements
- R1: The word address `cpu_addr` is split into offset `[OFF_W-1:0]`, set index `[OFF_W+IDX_W-1:OFF_W]` and tag (the remaining high bits). Memory line address `mem_addr` is `{tag, index}`. Word `k` of a line occupies bits `[k*WORD_W +: WORD_W]`. All words of one fetched line are served from the cache.
- R2: A way hits only when its valid bit is set and its stored tag equals the request tag. After reset every way is invalid, so the first access to any line misses.
- R3: A hit sets `cpu_done` for one cycle, exactly one clock after the request is seen. A read hit or a write-back write hit causes no memory transaction, and `mem_req` is low while `cpu_done` is high.
- R4: A miss issues one line read at `{tag, index}`. `mem_req`, `mem_we` and `mem_addr` hold steady until `mem_ack`. The requested word is then returned, with the cache's data taking precedence over memory data for any word the processor has written.
- R5: On a miss, an invalid way of the set is filled before any valid way is evicted. Two different lines that map to one set are therefore both resident after two misses.
- R6: With `REPL_LRU=1` the victim is the way accessed least recently. With `REPL_LRU=0` the victim is the way filled earliest, and hits do not change the order.
- R7: With `WRITE_BACK=1`, a write hit only marks the line dirty. A dirty victim is written to memory in full before the refill read is issued, and a clean victim is not written.
- R8: With `WRITE_BACK=0`, each processor write sends the updated line to memory. `cpu_done` is raised only after that write is acknowledged.
- R9: Under random mixed traffic every read returns the last value written to that address. After every line has been forced out, main memory equals the reference image.
- R10: While `rst` is high, `cpu_done` and `mem_req` are low on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | WORD_W | Write data |
| cpu_rdata | output | WORD_W | Read data, valid with `cpu_done` |
| cpu_done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory line request, held until `mem_ack` |
| mem_we | output | 1 | 1 = line write, 0 = line read |
| mem_addr | output | ADDR_W-OFF_W | Line address `{tag, index}` |
| mem_wdata | output | WORD_W*2**OFF_W | Line write data |
| mem_rdata | input | WORD_W*2**OFF_W | Line read data, valid with `mem_ack` |
| mem_ack | input | 1 | One-cycle memory completion |

## Verification
A hit must show `cpu_done` at the first falling edge after the clock edge that sees the request, so the bench counts falling edges from request to done and expects exactly one. A miss takes one cycle to issue the memory request, the memory latency, one cycle to install the line, and one more cycle for the replayed hit. Write-through writes add a further memory round trip, and the bench only requires these latencies to exceed one cycle. Traffic on the memory port is counted by the bench's memory model at its own acknowledge. Each count is read only after `cpu_done`, when every transaction caused by that access has finished.

// File: rtl/sa_cache_pkg.sv
package sa_cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_EVICT  = 2'd1,
    ST_REFILL = 2'd2,
    ST_WTHRU  = 2'd3
  } cache_st_e;

  localparam int NUM_WAYS = 2;
endpackage

// File: rtl/sa_cache_tags.sv
module sa_cache_tags #(
  parameter int TAG_W = 6,
  parameter int IDX_W = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [IDX_W-1:0]             rd_idx,
  input  logic [TAG_W-1:0]             cmp_tag,
  output logic [1:0]                   hit_o,
  output logic [1:0]                   valid_o,
  output logic [1:0]                   dirty_o,
  output logic [1:0][TAG_W-1:0]        tag_o,
  input  logic                         fill_en,
  input  logic                         fill_way,
  input  logic [IDX_W-1:0]             fill_idx,
  input  logic [TAG_W-1:0]             fill_tag,
  input  logic                         mark_en,
  input  logic                         mark_way,
  input  logic [IDX_W-1:0]             mark_idx
);
  localparam int SETS = 2**IDX_W;

  for (genvar w = 0; w < sa_cache_pkg::NUM_WAYS; w++) begin : g_way
    logic [TAG_W-1:0] tag_mem [SETS];
    logic [SETS-1:0]  vld_q;
    logic [SETS-1:0]  drt_q;
    logic             fill_here;
    logic             mark_here;

    assign fill_here = fill_en && (fill_way == 1'(w));
    assign mark_here = mark_en && (mark_way == 1'(w));

    always_ff @(posedge clk) begin
      if (fill_here) tag_mem[fill_idx] <= fill_tag;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q <= '0;
        drt_q <= '0;
      end else if (fill_here) begin
        vld_q[fill_idx] <= 1'b1;
        drt_q[fill_idx] <= 1'b0;
      end else if (mark_here) begin
        drt_q[mark_idx] <= 1'b1;
      end
    end

    assign tag_o[w]   = tag_mem[rd_idx];
    assign valid_o[w] = vld_q[rd_idx];
    assign dirty_o[w] = drt_q[rd_idx];
    assign hit_o[w]   = vld_q[rd_idx] && (tag_mem[rd_idx] == cmp_tag);
  end
endmodule

// File: rtl/sa_cache_repl.sv
module sa_cache_repl #(
  parameter int IDX_W    = 2,
  parameter bit REPL_LRU = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             victim_o,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic             touch_way,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic             fill_way
);
  localparam int SETS = 2**IDX_W;

  logic [SETS-1:0] next_out_q;

  if (REPL_LRU) begin : g_lru
    always_ff @(posedge clk) begin
      if (rst) begin
        next_out_q <= '0;
      end else if (touch_en) begin
        next_out_q[touch_idx] <= ~touch_way;
      end else if (fill_en) begin
        next_out_q[fill_idx] <= ~fill_way;
      end
    end
  end else begin : g_fifo
    logic unused_touch;
    assign unused_touch = ^{touch_en, touch_idx, touch_way};
    always_ff @(posedge clk) begin
      if (rst) begin
        next_out_q <= '0;
      end else if (fill_en) begin
        next_out_q[fill_idx] <= ~fill_way;
      end
    end
  end

  assign victim_o = next_out_q[rd_idx];
endmodule

// File: rtl/sa_cache_data.sv
module sa_cache_data #(
  parameter int IDX_W  = 2,
  parameter int LINE_W = 64
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic                    wr_way,
  input  logic [LINE_W-1:0]       wr_line,
  input  logic [IDX_W-1:0]        rd_idx,
  output logic [1:0][LINE_W-1:0]  rd_lines_o
);
  localparam int ENTRIES = 2**(IDX_W + 1);

  logic [LINE_W-1:0] line_mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (wr_en) line_mem[{wr_idx, wr_way}] <= wr_line;
  end

  for (genvar w = 0; w < sa_cache_pkg::NUM_WAYS; w++) begin : g_rd
    assign rd_lines_o[w] = line_mem[{rd_idx, 1'(w)}];
  end
endmodule

// File: rtl/sa_cache.sv
module sa_cache #(
  parameter int ADDR_W     = 10,
  parameter int WORD_W     = 16,
  parameter int IDX_W      = 2,
  parameter int OFF_W      = 2,
  parameter bit WRITE_BACK = 1'b1,
  parameter bit REPL_LRU   = 1'b1
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            cpu_req,
  input  logic                            cpu_we,
  input  logic [ADDR_W-1:0]               cpu_addr,
  input  logic [WORD_W-1:0]               cpu_wdata,
  output logic [WORD_W-1:0]               cpu_rdata,
  output logic                            cpu_done,
  output logic                            mem_req,
  output logic                            mem_we,
  output logic [ADDR_W-OFF_W-1:0]         mem_addr,
  output logic [WORD_W*(2**OFF_W)-1:0]    mem_wdata,
  input  logic [WORD_W*(2**OFF_W)-1:0]    mem_rdata,
  input  logic                            mem_ack
);
  import sa_cache_pkg::*;

  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int WPL    = 2**OFF_W;
  localparam int LINE_W = WORD_W * WPL;

  cache_st_e state_q;
  logic      done_q;
  logic      vict_q;
  logic [WORD_W-1:0] rdata_q;

  logic [TAG_W-1:0] req_tag;
  logic [IDX_W-1:0] req_idx;
  logic [OFF_W-1:0] req_off;

  assign req_tag = cpu_addr[ADDR_W-1 -: TAG_W];
  assign req_idx = cpu_addr[OFF_W +: IDX_W];
  assign req_off = cpu_addr[OFF_W-1:0];

  logic [1:0]             hit_vec;
  logic [1:0]             valid_vec;
  logic [1:0]             dirty_vec;
  logic [1:0][TAG_W-1:0]  way_tag;
  logic [1:0][LINE_W-1:0] way_line;
  logic                   repl_victim;

  logic              any_hit;
  logic              hit_way;
  logic [LINE_W-1:0] hit_line;
  logic [LINE_W-1:0] merged_line;
  logic [WORD_W-1:0] hit_word;
  logic              victim;
  logic              accept;
  logic              refill_done;

  assign any_hit     = |hit_vec;
  assign hit_way     = hit_vec[1];
  assign hit_line    = way_line[hit_way];
  assign hit_word    = hit_line[req_off*WORD_W +: WORD_W];
  assign accept      = (state_q == ST_IDLE) && cpu_req && !done_q;
  assign refill_done = (state_q == ST_REFILL) && mem_ack;

  always_comb begin
    merged_line = hit_line;
    merged_line[req_off*WORD_W +: WORD_W] = cpu_wdata;
  end

  always_comb begin
    if (!valid_vec[0])      victim = 1'b0;
    else if (!valid_vec[1]) victim = 1'b1;
    else                    victim = repl_victim;
  end

  logic              dw_en;
  logic              dw_way;
  logic [LINE_W-1:0] dw_line;

  assign dw_en   = (accept && any_hit && cpu_we) || refill_done;
  assign dw_way  = refill_done ? vict_q : hit_way;
  assign dw_line = refill_done ? mem_rdata : merged_line;

  sa_cache_tags #(.TAG_W(TAG_W), .IDX_W(IDX_W)) tags_i (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (req_idx),
    .cmp_tag  (req_tag),
    .hit_o    (hit_vec),
    .valid_o  (valid_vec),
    .dirty_o  (dirty_vec),
    .tag_o    (way_tag),
    .fill_en  (refill_done),
    .fill_way (vict_q),
    .fill_idx (req_idx),
    .fill_tag (req_tag),
    .mark_en  (WRITE_BACK && accept && any_hit && cpu_we),
    .mark_way (hit_way),
    .mark_idx (req_idx)
  );

  sa_cache_repl #(.IDX_W(IDX_W), .REPL_LRU(REPL_LRU)) repl_i (
    .clk       (clk),
    .rst       (rst),
    .rd_idx    (req_idx),
    .victim_o  (repl_victim),
    .touch_en  (accept && any_hit),
    .touch_idx (req_idx),
    .touch_way (hit_way),
    .fill_en   (refill_done),
    .fill_idx  (req_idx),
    .fill_way  (vict_q)
  );

  sa_cache_data #(.IDX_W(IDX_W), .LINE_W(LINE_W)) data_i (
    .clk        (clk),
    .wr_en      (dw_en),
    .wr_idx     (req_idx),
    .wr_way     (dw_way),
    .wr_line    (dw_line),
    .rd_idx     (req_idx),
    .rd_lines_o (way_line)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      done_q    <= 1'b0;
      vict_q    <= 1'b0;
      rdata_q   <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (any_hit) begin
              if (!cpu_we) begin
                rdata_q <= hit_word;
                done_q  <= 1'b1;
              end else if (WRITE_BACK) begin
                done_q  <= 1'b1;
              end else begin
                mem_req   <= 1'b1;
                mem_we    <= 1'b1;
                mem_addr  <= {req_tag, req_idx};
                mem_wdata <= merged_line;
                state_q   <= ST_WTHRU;
              end
            end else begin
              vict_q  <= victim;
              mem_req <= 1'b1;
              if (WRITE_BACK && valid_vec[victim] && dirty_vec[victim]) begin
                mem_we    <= 1'b1;
                mem_addr  <= {way_tag[victim], req_idx};
                mem_wdata <= way_line[victim];
                state_q   <= ST_EVICT;
              end else begin
                mem_we    <= 1'b0;
                mem_addr  <= {req_tag, req_idx};
                state_q   <= ST_REFILL;
              end
            end
          end
        end
        ST_EVICT: begin
          if (mem_ack) begin
            mem_we   <= 1'b0;
            mem_addr <= {req_tag, req_idx};
            state_q  <= ST_REFILL;
          end
        end
        ST_REFILL: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        ST_WTHRU: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cpu_done  = done_q;
  assign cpu_rdata = rdata_q;
endmodule

// File: rtl/sa_cache_chk.sv
module sa_cache_chk #(
  parameter bit WRITE_BACK = 1'b1,
  parameter int LADDR_W    = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               cpu_we,
  input logic               cpu_done,
  input logic               mem_req,
  input logic               mem_we,
  input logic [LADDR_W-1:0] mem_addr,
  input logic               mem_ack
);
  p_reset_quiet_r10: assert property (@(posedge clk)
    rst |=> !cpu_done && !mem_req);

  p_mem_hold_r4: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr));

  p_done_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    cpu_done |-> !mem_req);

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    cpu_done |=> !cpu_done);

  if (WRITE_BACK) begin : g_wb
    logic unused_we;
    assign unused_we = cpu_we;
    p_evict_then_fill_r7: assert property (@(posedge clk) disable iff (rst)
      mem_req && mem_we && mem_ack |=> mem_req && !mem_we);
  end else begin : g_wt
    p_write_through_r8: assert property (@(posedge clk) disable iff (rst)
      cpu_done && cpu_we |-> $past(mem_req && mem_we && mem_ack));
  end
endmodule

bind sa_cache sa_cache_chk #(
  .WRITE_BACK (WRITE_BACK),
  .LADDR_W    (ADDR_W - OFF_W)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .cpu_we   (cpu_we),
  .cpu_done (cpu_done),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .mem_ack  (mem_ack)
);

// File: tb/sa_cache_tb_top.sv
`timescale 1ns/1ps

module sa_cache_tb_mem #(
  parameter int LA_W   = 8,
  parameter int LINE_W = 64,
  parameter int LAT    = 3
) (
  input  logic              clk,
  input  logic              req,
  input  logic              we,
  input  logic [LA_W-1:0]   addr,
  input  logic [LINE_W-1:0] wdata,
  output logic [LINE_W-1:0] rdata,
  output logic              ack
);
  localparam int WPL = LINE_W / 16;

  logic [LINE_W-1:0] lines [2**LA_W];
  int rd_cnt = 0;
  int wr_cnt = 0;
  int cnt    = 0;
  logic [3:0] seq = '0;

  function automatic logic [15:0] pat(input int a);
    return 16'(a * 257 + 3);
  endfunction

  initial begin
    ack   = 1'b0;
    rdata = '0;
    for (int i = 0; i < 2**LA_W; i++)
      for (int k = 0; k < WPL; k++)
        lines[i][k*16 +: 16] = pat(i * WPL + k);
  end

  always @(negedge clk) begin
    if (ack) begin
      ack = 1'b0;
    end else if (req) begin
      if (cnt == LAT - 1) begin
        cnt = 0;
        ack = 1'b1;
        seq = {seq[2:0], we};
        if (we) begin
          lines[addr] = wdata;
          wr_cnt++;
        end else begin
          rdata = lines[addr];
          rd_cnt++;
        end
      end else begin
        cnt++;
      end
    end
  end
endmodule

module sa_cache_tb_top;
  localparam int AW = 10;
  localparam int LA = 8;
  localparam int LW = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [1:0]    c_req = '0;
  logic [1:0]    c_we  = '0;
  logic [AW-1:0] c_addr [2];
  logic [15:0]   c_wd   [2];
  logic [15:0]   c_rd   [2];
  logic [1:0]    c_done;
  logic [1:0]    m_req, m_we, m_ack;
  logic [LA-1:0] m_addr [2];
  logic [LW-1:0] m_wd   [2];
  logic [LW-1:0] m_rd   [2];

  logic [15:0] ref_mem [2][1024];
  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;

  // unit 0: write-back, LRU. unit 1: write-through, FIFO.
  sa_cache #(.WRITE_BACK(1'b1), .REPL_LRU(1'b1)) dut_i (
    .clk(clk), .rst(rst), .cpu_req(c_req[0]), .cpu_we(c_we[0]),
    .cpu_addr(c_addr[0]), .cpu_wdata(c_wd[0]), .cpu_rdata(c_rd[0]),
    .cpu_done(c_done[0]), .mem_req(m_req[0]), .mem_we(m_we[0]),
    .mem_addr(m_addr[0]), .mem_wdata(m_wd[0]), .mem_rdata(m_rd[0]),
    .mem_ack(m_ack[0]));

  sa_cache #(.WRITE_BACK(1'b0), .REPL_LRU(1'b0)) dut_wt_i (
    .clk(clk), .rst(rst), .cpu_req(c_req[1]), .cpu_we(c_we[1]),
    .cpu_addr(c_addr[1]), .cpu_wdata(c_wd[1]), .cpu_rdata(c_rd[1]),
    .cpu_done(c_done[1]), .mem_req(m_req[1]), .mem_we(m_we[1]),
    .mem_addr(m_addr[1]), .mem_wdata(m_wd[1]), .mem_rdata(m_rd[1]),
    .mem_ack(m_ack[1]));

  sa_cache_tb_mem #(.LA_W(LA), .LINE_W(LW), .LAT(3)) m0 (
    .clk(clk), .req(m_req[0]), .we(m_we[0]), .addr(m_addr[0]),
    .wdata(m_wd[0]), .rdata(m_rd[0]), .ack(m_ack[0]));

  sa_cache_tb_mem #(.LA_W(LA), .LINE_W(LW), .LAT(3)) m1 (
    .clk(clk), .req(m_req[1]), .we(m_we[1]), .addr(m_addr[1]),
    .wdata(m_wd[1]), .rdata(m_rd[1]), .ack(m_ack[1]));

  function automatic logic [15:0] pat(input int a);
    return 16'(a * 257 + 3);
  endfunction

  function automatic logic [AW-1:0] mk(input int t, input int i, input int o);
    return {6'(t), 2'(i), 2'(o)};
  endfunction

  function automatic int rdc(input int u);
    return (u == 1) ? m1.rd_cnt : m0.rd_cnt;
  endfunction

  function automatic int wrc(input int u);
    return (u == 1) ? m1.wr_cnt : m0.wr_cnt;
  endfunction

  function automatic logic [LW-1:0] mline(input int u, input int la);
    return (u == 1) ? m1.lines[la] : m0.lines[la];
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input int u, input bit we, input logic [AW-1:0] a,
                        input logic [15:0] wd, output logic [15:0] rd, output int lat);
    @(negedge clk);
    c_we[u] = we; c_addr[u] = a; c_wd[u] = wd; c_req[u] = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!c_done[u] && lat < 300);
    rd = c_rd[u];
    c_req[u] = 1'b0;
    if (we) ref_mem[u][a] = wd;
    if (lat >= 300) chk(1'b0, "stuck request", lat, 0);
  endtask

  task automatic t_reset();
    for (int u = 0; u < 2; u++) begin
      chk(c_done[u] == 1'b0, "R10 done low after reset", c_done[u], 0);
      chk(m_req[u] == 1'b0, "R10 mem_req low after reset", m_req[u], 0);
    end
  endtask

  task automatic t_fill(input int u);
    logic [15:0] rd; int lat; int r0;
    r0 = rdc(u);
    access(u, 1'b0, mk(1, 0, 2), '0, rd, lat);
    chk(rd == ref_mem[u][mk(1, 0, 2)], "R4 miss returns word", rd, ref_mem[u][mk(1, 0, 2)]);
    chk(rdc(u) - r0 == 1, "R4 one line read", rdc(u) - r0, 1);
    chk(lat > 1, "R2 first access misses", lat, 2);
    for (int o = 0; o < 4; o++) begin
      if (o == 2) continue;
      access(u, 1'b0, mk(1, 0, o), '0, rd, lat);
      chk(rd == ref_mem[u][mk(1, 0, o)], "R1 word from same line", rd, ref_mem[u][mk(1, 0, o)]);
      chk(lat == 1, "R3 hit latency", lat, 1);
    end
    chk(rdc(u) - r0 == 1, "R3 hits cause no reads", rdc(u) - r0, 1);
  endtask

  task automatic t_invalid_first(input int u);
    logic [15:0] rd; int lat; int r0;
    access(u, 1'b0, mk(2, 1, 0), '0, rd, lat);
    access(u, 1'b0, mk(3, 1, 0), '0, rd, lat);
    r0 = rdc(u);
    access(u, 1'b0, mk(2, 1, 1), '0, rd, lat);
    chk(rdc(u) == r0, "R5 first line kept", rdc(u) - r0, 0);
    chk(rd == ref_mem[u][mk(2, 1, 1)], "R5 value", rd, ref_mem[u][mk(2, 1, 1)]);
  endtask

  task automatic t_repl(input int u);
    logic [15:0] rd; int lat; int r0; int exp;
    access(u, 1'b0, mk(4, 2, 0), '0, rd, lat);
    access(u, 1'b0, mk(5, 2, 0), '0, rd, lat);
    access(u, 1'b0, mk(4, 2, 1), '0, rd, lat);
    access(u, 1'b0, mk(6, 2, 0), '0, rd, lat);
    r0 = rdc(u);
    access(u, 1'b0, mk(4, 2, 2), '0, rd, lat);
    exp = (u == 0) ? 0 : 1;   // LRU keeps the re-used line; FIFO drops the oldest fill
    chk(rdc(u) - r0 == exp, "R6 victim choice", rdc(u) - r0, exp);
    chk(rd == ref_mem[u][mk(4, 2, 2)], "R6 value", rd, ref_mem[u][mk(4, 2, 2)]);
  endtask

  task automatic t_write_back();
    logic [15:0] rd; int lat; int w0; logic [LW-1:0] ln;
    access(0, 1'b1, mk(7, 3, 1), 16'hBEEF, rd, lat);
    w0 = wrc(0);
    access(0, 1'b1, mk(7, 3, 2), 16'h1234, rd, lat);
    chk(lat == 1, "R7 write hit latency", lat, 1);
    chk(wrc(0) == w0, "R7 write hit no memory write", wrc(0) - w0, 0);
    access(0, 1'b0, mk(8, 3, 0), '0, rd, lat);
    chk(wrc(0) == w0, "R7 clean fill no write", wrc(0) - w0, 0);
    access(0, 1'b0, mk(9, 3, 0), '0, rd, lat);
    chk(wrc(0) - w0 == 1, "R7 dirty victim written", wrc(0) - w0, 1);
    chk(m0.seq[1:0] == 2'b10, "R7 write before refill", m0.seq[1:0], 2'b10);
    ln = mline(0, {6'd7, 2'd3});
    chk(ln[16 +: 16] == 16'hBEEF, "R7 written line word1", ln[16 +: 16], 16'hBEEF);
    chk(ln[32 +: 16] == 16'h1234, "R7 written line word2", ln[32 +: 16], 16'h1234);
  endtask

  task automatic t_write_through();
    logic [15:0] rd; int lat; int w0; logic [LW-1:0] ln;
    w0 = wrc(1);
    access(1, 1'b1, mk(7, 3, 1), 16'hBEEF, rd, lat);
    chk(wrc(1) - w0 == 1, "R8 miss write reaches memory", wrc(1) - w0, 1);
    ln = mline(1, {6'd7, 2'd3});
    chk(ln[16 +: 16] == 16'hBEEF, "R8 memory word", ln[16 +: 16], 16'hBEEF);
    w0 = wrc(1);
    access(1, 1'b1, mk(7, 3, 2), 16'h1234, rd, lat);
    chk(wrc(1) - w0 == 1, "R8 hit write reaches memory", wrc(1) - w0, 1);
    chk(lat > 1, "R8 done waits for memory", lat, 2);
  endtask

  task automatic t_random(input int u);
    logic [15:0] rd; int lat; logic [AW-1:0] a; bit we; int bad;
    bad = 0;
    for (int n = 0; n < 300; n++) begin
      a  = mk($urandom_range(0, 11), $urandom_range(0, 3), $urandom_range(0, 3));
      we = ($urandom_range(0, 2) == 0);
      if (we) begin
        access(u, 1'b1, a, 16'($urandom), rd, lat);
      end else begin
        access(u, 1'b0, a, '0, rd, lat);
        if (rd != ref_mem[u][a]) begin
          bad++;
          chk(1'b0, "R9 random read", rd, ref_mem[u][a]);
        end
      end
    end
    chk(bad == 0, "R9 random traffic", bad, 0);
  endtask

  task automatic t_flush(input int u);
    logic [15:0] rd; int lat; int bad; logic [LW-1:0] ln;
    for (int i = 0; i < 4; i++) begin
      access(u, 1'b0, mk(62, i, 0), '0, rd, lat);
      access(u, 1'b0, mk(63, i, 0), '0, rd, lat);
    end
    bad = 0;
    for (int la = 0; la < 2**LA; la++) begin
      ln = mline(u, la);
      for (int k = 0; k < 4; k++)
        if (ln[k*16 +: 16] != ref_mem[u][la*4 + k]) bad++;
    end
    chk(bad == 0, "R9 final memory image", bad, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int u = 0; u < 2; u++) begin
      c_addr[u] = '0;
      c_wd[u]   = '0;
      for (int a = 0; a < 1024; a++) ref_mem[u][a] = pat(a);
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    for (int u = 0; u < 2; u++) begin
      t_fill(u);
      t_invalid_first(u);
      t_repl(u);
    end
    t_write_back();
    t_write_through();
    for (int u = 0; u < 2; u++) begin
      t_random(u);
      t_flush(u);
    end
    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule